// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This unit sits in the execute stage of a small in-order core that runs branch-free, single-path code. It keeps a dedicated condition bit that is separate from the ordinary arithmetic flags. Only committed compare instructions write this bit. Move and arithmetic instructions may carry a predicate. The predicate names the truth value of the condition bit that the instruction needs in order to take effect.

For each instruction in the execute slot, the unit decides whether the instruction commits or is squashed. A squashed instruction still takes its one slot, so the cycle count of a program does not depend on data. A squashed instruction writes no register, changes no flag and leaves the condition bit unchanged.

The unit produces three results: the writeback enable for the register file, the zero/carry/negative/overflow flags of committed arithmetic, and a retire pulse for every valid instruction. An if/else selection can therefore be written as a compare followed by a move-on-true and a move-on-false.

Top module: `pred_cond_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `cond_o`, `flags_o`, `wb_en_o` and `retire_o` to 0.
- R2: A committed compare (`opclass_i`=2) sets `cond_o` after the edge. The value depends on `cmp_kind_i`:
  - 0: a==b
  - 1: a!=b
  - 2: signed a<b
  - 3: signed a>=b
  - 4: unsigned a<b
  - 5: unsigned a>=b
- R3: Arithmetic instructions (`opclass_i`=1) never change `cond_o`.
- R4: Move (`opclass_i`=0) and no-writeback (`opclass_i`=3) instructions never change `cond_o`.
- R5: An instruction commits when `valid_i` is high and either `pred_en_i` is 0 or the current `cond_o` equals `pred_val_i`.
- R6: A squashed instruction gives `wb_en_o`=0 and leaves `flags_o` and `cond_o` unchanged. This includes a squashed compare.
- R7: `wb_en_o` is high for the one cycle after the edge at which a move or arithmetic instruction commits. It is low after every other edge.
- R8: A committed arithmetic instruction loads `flags_o`={Z,C,N,V} (bit 3 down to bit 0) from a+b when `sub_i`=0, or from a-b computed as a+~b+1 when `sub_i`=1. The flags are:
  - Z: the result is zero.
  - C: carry out of the top bit.
  - N: the result's top bit.
  - V: signed overflow.
- R9: Move, compare and no-writeback instructions leave `flags_o` unchanged.
- R10: `retire_o` is high for the one cycle after every edge with `valid_i` high, whether the instruction commits or is squashed. It is low otherwise.
- R11: A cycle with `valid_i` low changes neither `cond_o` nor `flags_o`, and gives `wb_en_o`=0.
- R12: A committed compare with `cmp_kind_i` 6 or 7 clears `cond_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present in execute slot |
| opclass_i | input | 2 | 0 move, 1 arithmetic, 2 compare, 3 no writeback |
| cmp_kind_i | input | 3 | Compare type (see R2, R12) |
| sub_i | input | 1 | Arithmetic: 0 add, 1 subtract |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| pred_en_i | input | 1 | Instruction is predicated |
| pred_val_i | input | 1 | Required condition value |
| cond_o | output | 1 | Condition bit |
| wb_en_o | output | 1 | Register writeback enable |
| flags_o | output | 4 | {Z,C,N,V} arithmetic flags |
| retire_o | output | 1 | Instruction slot consumed |

## Verification
All four results are registered, so each one is due exactly one clock after the edge that samples the instruction. The predicate is tested against the condition bit as it stands before that edge. The bench drives each instruction on a falling edge, waits for the next rising edge, and compares every output shortly after that edge against its own model. The model is then advanced for the next instruction. A four-bit configuration allows exhaustive sweeps of every compare type and of add and subtract over all operand pairs. These are followed by every combination of class, predicate and condition value.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    CLS_MOVE  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_CMP   = 2'd2,
    CLS_NOWB  = 2'd3
  } op_class_e;

  localparam logic [2:0] CMP_EQ  = 3'd0;
  localparam logic [2:0] CMP_NE  = 3'd1;
  localparam logic [2:0] CMP_LTS = 3'd2;
  localparam logic [2:0] CMP_GES = 3'd3;
  localparam logic [2:0] CMP_LTU = 3'd4;
  localparam logic [2:0] CMP_GEU = 3'd5;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/pcu_compare.sv
module pcu_compare #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       kind_i,
  output logic             hit_o
);
  import pcu_pkg::*;
  logic eq, lt_s, lt_u;

  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    case (kind_i)
      CMP_EQ:  hit_o = eq;
      CMP_NE:  hit_o = !eq;
      CMP_LTS: hit_o = lt_s;
      CMP_GES: hit_o = !lt_s;
      CMP_LTU: hit_o = lt_u;
      CMP_GEU: hit_o = !lt_u;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcu_flags.sv
module pcu_flags #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]        a_i,
  input  logic [WIDTH-1:0]        b_i,
  input  logic                    sub_i,
  output pcu_pkg::alu_flags_t     flags_o
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] res;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign res   = sum[WIDTH-1:0];

  always_comb begin
    flags_o.z = (res == '0);
    flags_o.c = sum[WIDTH];
    flags_o.n = res[MSB];
    flags_o.v = (a_i[MSB] == b_eff[MSB]) && (res[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/pcu_gate.sv
module pcu_gate (
  input  logic valid_i,
  input  logic pred_en_i,
  input  logic pred_val_i,
  input  logic cond_i,
  output logic commit_o
);
  assign commit_o = valid_i && (!pred_en_i || (cond_i == pred_val_i));
endmodule

// File: rtl/pred_cond_unit.sv
module pred_cond_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [1:0]       opclass_i,
  input  logic [2:0]       cmp_kind_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             pred_en_i,
  input  logic             pred_val_i,
  output logic             cond_o,
  output logic             wb_en_o,
  output logic [3:0]       flags_o,
  output logic             retire_o
);
  import pcu_pkg::*;

  op_class_e  cls;
  logic       commit;
  logic       cmp_hit;
  alu_flags_t next_flags;
  alu_flags_t flags_q;

  assign cls = op_class_e'(opclass_i);

  pcu_gate u_gate (
    .valid_i   (valid_i),
    .pred_en_i (pred_en_i),
    .pred_val_i(pred_val_i),
    .cond_i    (cond_o),
    .commit_o  (commit)
  );

  pcu_compare #(.WIDTH(WIDTH)) u_cmp (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .kind_i(cmp_kind_i),
    .hit_o (cmp_hit)
  );

  pcu_flags #(.WIDTH(WIDTH)) u_flags (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .sub_i  (sub_i),
    .flags_o(next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_o   <= 1'b0;
      wb_en_o  <= 1'b0;
      flags_q  <= '0;
      retire_o <= 1'b0;
    end else begin
      retire_o <= valid_i;
      wb_en_o  <= commit && (cls == CLS_MOVE || cls == CLS_ARITH);
      if (commit && cls == CLS_CMP)   cond_o  <= cmp_hit;
      if (commit && cls == CLS_ARITH) flags_q <= next_flags;
    end
  end

  assign flags_o = flags_q;

  assert_cond_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(valid_i && opclass_i == 2'd2) |=> $stable(cond_o));

  assert_squash_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && pred_en_i && (pred_val_i != cond_o))
      |=> (!wb_en_o && $stable(cond_o) && $stable(flags_o)));

  assert_wb_class_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opclass_i[1]) |=> !wb_en_o);

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(valid_i && opclass_i == 2'd1) |=> $stable(flags_o));

  assert_retire_R10: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> retire_o);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!retire_o && !wb_en_o));
endmodule

// File: tb/test_pred_cond_unit.sv
module test_pred_cond_unit;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic         valid_i;
  logic [1:0]   opclass_i;
  logic [2:0]   cmp_kind_i;
  logic         sub_i;
  logic [W-1:0] op_a_i, op_b_i;
  logic         pred_en_i, pred_val_i;
  logic         cond_o, wb_en_o, retire_o;
  logic [3:0]   flags_o;

  int checks = 0;
  int errors = 0;
  logic       m_cond;
  logic [3:0] m_flags;

  always #5 clk = ~clk;

  pred_cond_unit #(.WIDTH(W)) i_pred_cond_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .opclass_i(opclass_i),
    .cmp_kind_i(cmp_kind_i), .sub_i(sub_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .pred_en_i(pred_en_i), .pred_val_i(pred_val_i), .cond_o(cond_o),
    .wb_en_o(wb_en_o), .flags_o(flags_o), .retire_o(retire_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x >= M/2) ? x - M : x;
  endfunction

  function automatic logic ref_cmp(input int k, input int a, input int b);
    case (k)
      0: return a == b;
      1: return a != b;
      2: return sgn(a) < sgn(b);
      3: return sgn(a) >= sgn(b);
      4: return a < b;
      5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] ref_flags(input int a, input int b, input int s);
    int full, res, sres;
    logic z, c, n, v;
    full = s ? (a + (M - 1 - b) + 1) : (a + b);
    res  = full % M;
    sres = s ? (sgn(a) - sgn(b)) : (sgn(a) + sgn(b));
    z = (res == 0);
    c = (full >= M);
    n = (res >= M/2);
    v = (sres < -(M/2)) || (sres > M/2 - 1);
    return {z, c, n, v};
  endfunction

  // Issue one instruction and check all outputs one edge later.
  task automatic step(input string tag, input int v, input int cls, input int k,
                      input int s, input int a, input int b, input int pe, input int pv);
    logic commit, exp_wb;
    @(negedge clk);
    valid_i = v[0]; opclass_i = cls[1:0]; cmp_kind_i = k[2:0]; sub_i = s[0];
    op_a_i = a[W-1:0]; op_b_i = b[W-1:0]; pred_en_i = pe[0]; pred_val_i = pv[0];
    commit = v[0] && (!pe[0] || (m_cond == pv[0]));
    exp_wb = commit && (cls == 0 || cls == 1);
    if (commit && cls == 2) m_cond = ref_cmp(k, a, b);
    if (commit && cls == 1) m_flags = ref_flags(a, b, s);
    @(posedge clk); #1;
    chk({tag, " cond"},   int'(cond_o),   int'(m_cond));
    chk({tag, " flags"},  int'(flags_o),  int'(m_flags));
    chk({tag, " wb_en"},  int'(wb_en_o),  int'(exp_wb));
    chk({tag, " retire"}, int'(retire_o), v);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 0; opclass_i = 0; cmp_kind_i = 0; sub_i = 0;
    op_a_i = 0; op_b_i = 0; pred_en_i = 0; pred_val_i = 0;
    m_cond = 0; m_flags = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cond",   int'(cond_o),   0);
    chk("R1 flags",  int'(flags_o),  0);
    chk("R1 wb_en",  int'(wb_en_o),  0);
    chk("R1 retire", int'(retire_o), 0);
    @(negedge clk); rst = 1'b0;

    // R2 / R12: every compare type over all operand pairs; flags held (R9)
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          step(k < 6 ? "R2 compare" : "R12 reserved compare", 1, 2, k, 0, a, b, 0, 0);

    // R8 / R3: add and subtract over all operand pairs, cond untouched
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          step("R8 R3 arith", 1, 1, 0, s, a, b, 0, 0);

    // R4 / R9: moves and no-writeback ops leave cond and flags alone
    step("R4 set cond", 1, 2, 0, 0, 5, 5, 0, 0);
    step("R4 move", 1, 0, 1, 0, 5, 5, 0, 0);
    step("R9 nowb", 1, 3, 1, 1, 9, 3, 0, 0);

    // R5 / R6 / R7: every class x predicate x condition value
    for (int c = 0; c < 2; c++)
      for (int cls = 0; cls < 4; cls++)
        for (int pe = 0; pe < 2; pe++)
          for (int pv = 0; pv < 2; pv++) begin
            step("R5 preset", 1, 2, c ? 0 : 1, 0, 3, 3, 0, 0);
            step("R6 R7 predicated", 1, cls, 1, 1, 2, 7, pe, pv);
          end

    // R6: squashed compare must not flip cond
    step("R6 preset", 1, 2, 0, 0, 1, 1, 0, 0);
    step("R6 squashed cmp", 1, 2, 1, 0, 1, 1, 1, 0);

    // if/else selection: exactly one of move-on-true / move-on-false writes
    step("R5 ifelse cmp", 1, 2, 2, 0, 12, 3, 0, 0);
    step("R5 movt", 1, 0, 0, 0, 0, 0, 1, 1);
    step("R5 movf", 1, 0, 0, 0, 0, 0, 1, 0);

    // R11 / R10: idle cycles with arithmetic and compare fields present
    step("R11 idle arith", 0, 1, 0, 1, 0, 1, 0, 0);
    step("R11 idle cmp", 0, 2, 1, 0, 0, 1, 0, 0);
    step("R10 back to valid", 1, 3, 0, 0, 0, 0, 0, 0);

    // R1: reset mid-run clears everything again
    step("R1 pre", 1, 1, 0, 1, 0, 1, 0, 0);
    @(negedge clk); rst = 1'b1; valid_i = 1'b0;
    @(posedge clk); #1;
    chk("R1 rerun cond",  int'(cond_o),  0);
    chk("R1 rerun flags", int'(flags_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule